// File: doc/BRIEF.md
# External Trigger Conditioner

This block prepares one external trigger signal for a timer. A source multiplexer picks one candidate: a device pin, one of two comparator outputs or one of three analog-watchdog flags. An optional inversion lets falling edges or low levels count as active. The result is brought into the block clock by a two-flop synchroniser. An edge-rate divider then passes one rising edge for every 1, 2, 4 or 8 rising edges at its input. A counter-based glitch filter comes last: it accepts a new level only after that level has been stable for a programmed number of samples.

The conditioned level fans out to three timer consumers: the external counter-clock path, the slave-mode trigger input and the PWM clear input used for cycle-by-cycle current limiting. One-clock strobes mark each rising and each falling transition of that level, so a consumer can use either the level or an edge. A sampling enable paces the filter at the slower sampling rate. It is held high whenever the filter should sample on every clock.

Top module: `ext_trig_conditioner`

## Requirements
- R1: While reset is high and on the first cycle after it, the conditioned level, the rising strobe and the falling strobe are all 0.
- R2: The source code picks the candidate: 0 the pin, 1 comparator 0, 2 comparator 1, 3 to 5 watchdog flags 0 to 2. Codes 6 to 15 give a constant low, whatever the candidate inputs are.
- R3: When the invert control is 1, the selected candidate is complemented before any later stage.
- R4: With divide code 0 and filter code 0, a change on the selected input shows on the conditioned level on the 4th rising clock edge after it is applied, and not before.
- R5: The divide code sets the ratio: 0 gives /1 (the level follows its input), 1 gives /2, 2 gives /4 and 3 gives /8. With ratio N (N > 1), starting from a cleared divider, every N input rising edges give exactly one output rising edge.
- R6: Writing a new divide code clears the divider count and forces its output low.
- R7: With filter code F > 0 and the sampling enable held high, an input level that differs from the output for F or fewer consecutive clocks is ignored. One that differs for F+1 consecutive clocks is taken on.
- R8: With a non-zero filter code, the filtered level does not change while the sampling enable is low.
- R9: The rising and falling strobes are each high for exactly one clock, in the cycle in which the level has just changed to 1 or to 0. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_pin | input | 1 | Trigger candidate from the device pin (source code 0) |
| cmp_out | input | 2 | Comparator outputs (source codes 1 and 2) |
| wdg_flag | input | 3 | Analog-watchdog flags (source codes 3 to 5) |
| cfg_src | input | 4 | Source select code |
| cfg_invert | input | 1 | 1 complements the selected candidate |
| cfg_div | input | 2 | Edge-rate divide code |
| cfg_filt | input | 4 | Filter length code; 0 bypasses the filter |
| samp_en | input | 1 | Sampling enable for the filter |
| trig_level | output | 1 | Conditioned trigger level |
| trig_rise | output | 1 | One-clock strobe on a rising level transition |
| trig_fall | output | 1 | One-clock strobe on a falling level transition |

## Verification
The assertions assume that the divide and filter codes stay constant while the trigger is active. A code change is seen only by the stage it belongs to, and the divider and filter checks hold only once the new code has been in place for a cycle. The candidate inputs are treated as asynchronous, so nothing is assumed about how they relate to the clock. The stimulus changes configuration only while the selected input is idle, and then waits several clocks before it applies trigger activity. It sends random candidate vectors and pulse widths only while the configuration is stable.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

    localparam int SEL_W     = 4;
    localparam int DIV_CODE_W = 2;
    localparam int FILT_W    = 4;
    localparam int DIV_CNT_W = 3;

    typedef enum logic [DIV_CODE_W-1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2,
        DIV_BY8 = 2'd3
    } div_code_e;

    typedef struct packed {
        logic [SEL_W-1:0]      src;
        logic                  invert;
        logic [DIV_CODE_W-1:0] div;
        logic [FILT_W-1:0]     filt;
    } trig_cfg_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } trig_evt_t;

    // Input rising edges per divider toggle, minus one
    function automatic logic [DIV_CNT_W-1:0] toggle_limit(input logic [DIV_CODE_W-1:0] code);
        case (code)
            DIV_BY2: toggle_limit = DIV_CNT_W'(0);
            DIV_BY4: toggle_limit = DIV_CNT_W'(1);
            DIV_BY8: toggle_limit = DIV_CNT_W'(3);
            default: toggle_limit = DIV_CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/trig_src_select.sv
module trig_src_select
    import trig_cond_pkg::*;
#(
    parameter int NUM_CMP     = 2,
    parameter int NUM_WDG     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_i,
    input  logic [NUM_CMP-1:0] cmp_i,
    input  logic [NUM_WDG-1:0] wdg_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               invert_i,
    output logic               sync_o
);

    localparam int NUM_SRC = 1 + NUM_CMP + NUM_WDG;

    logic [NUM_SRC-1:0]     cand;
    logic                   picked;
    logic                   polar;
    logic [SYNC_STAGES-1:0] stg;

    assign cand = {wdg_i, cmp_i, pin_i};

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) picked = cand[i];
        end
    end

    assign polar = picked ^ invert_i;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[SYNC_STAGES-2:0], polar};
    end

    assign sync_o = stg[SYNC_STAGES-1];

    // R2
    unused_src_low_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(sel_i) >= NUM_SRC && !invert_i) |=> !stg[0]);

endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler
    import trig_cond_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_i,
    input  logic [DIV_CODE_W-1:0] div_i,
    output logic                  out_o
);

    logic                  in_q;
    logic                  in_rise;
    logic [DIV_CNT_W-1:0]  cnt;
    logic                  div_q;
    logic [DIV_CODE_W-1:0] code_q;

    assign in_rise = in_i & ~in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= 1'b0;
            cnt    <= '0;
            div_q  <= 1'b0;
            code_q <= DIV_BY1;
        end else begin
            in_q   <= in_i;
            code_q <= div_i;
            if (div_i != code_q) begin
                cnt   <= '0;
                div_q <= 1'b0;
            end else if (div_i == DIV_BY1) begin
                cnt   <= '0;
                div_q <= in_i;
            end else if (in_rise) begin
                if (cnt == toggle_limit(div_i)) begin
                    cnt   <= '0;
                    div_q <= ~div_q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign out_o = div_q;

    // R5
    div_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (div_i == code_q) |-> (cnt <= toggle_limit(div_i)));

    // R6
    div_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (div_i != code_q) |=> (cnt == '0 && !div_q));

endmodule

// File: rtl/trig_glitch_filter.sv
module trig_glitch_filter
    import trig_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_i,
    input  logic              samp_en_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              out_o
);

    logic [FILT_W-1:0] cnt;
    logic [FILT_W-1:0] len_q;
    logic              out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            len_q <= '0;
            out_q <= 1'b0;
        end else begin
            len_q <= len_i;
            if (len_i == '0) begin
                out_q <= in_i;
                cnt   <= '0;
            end else if (len_i != len_q) begin
                cnt <= len_i;
            end else if (samp_en_i) begin
                if (in_i == out_q) begin
                    cnt <= len_i;
                end else if (cnt == '0) begin
                    out_q <= in_i;
                    cnt   <= len_i;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assign out_o = out_q;

    // R8
    filt_samp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (len_i != '0 && len_i == len_q && !samp_en_i) |=> $stable(out_q));

    // R7
    filt_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (len_i != '0 && len_i == len_q && cnt != '0) |=> $stable(out_q));

endmodule

// File: rtl/ext_trig_conditioner.sv
module ext_trig_conditioner
    import trig_cond_pkg::*;
#(
    parameter int NUM_CMP     = 2,
    parameter int NUM_WDG     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_pin,
    input  logic [NUM_CMP-1:0]    cmp_out,
    input  logic [NUM_WDG-1:0]    wdg_flag,
    input  logic [SEL_W-1:0]      cfg_src,
    input  logic                  cfg_invert,
    input  logic [DIV_CODE_W-1:0] cfg_div,
    input  logic [FILT_W-1:0]     cfg_filt,
    input  logic                  samp_en,
    output logic                  trig_level,
    output logic                  trig_rise,
    output logic                  trig_fall
);

    trig_cfg_t cfg;
    trig_evt_t evt;
    logic      synced;
    logic      divided;
    logic      filtered;
    logic      level_q;

    always_comb begin
        cfg.src    = cfg_src;
        cfg.invert = cfg_invert;
        cfg.div    = cfg_div;
        cfg.filt   = cfg_filt;
    end

    trig_src_select #(
        .NUM_CMP    (NUM_CMP),
        .NUM_WDG    (NUM_WDG),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_select (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (trig_pin),
        .cmp_i   (cmp_out),
        .wdg_i   (wdg_flag),
        .sel_i   (cfg.src),
        .invert_i(cfg.invert),
        .sync_o  (synced)
    );

    trig_prescaler u_div (
        .clk  (clk),
        .rst  (rst),
        .in_i (synced),
        .div_i(cfg.div),
        .out_o(divided)
    );

    trig_glitch_filter u_filt (
        .clk      (clk),
        .rst      (rst),
        .in_i     (divided),
        .samp_en_i(samp_en),
        .len_i    (cfg.filt),
        .out_o    (filtered)
    );

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= filtered;
    end

    always_comb begin
        evt.level = filtered;
        evt.rise  = filtered & ~level_q;
        evt.fall  = ~filtered & level_q;
    end

    assign trig_level = evt.level;
    assign trig_rise  = evt.rise;
    assign trig_fall  = evt.fall;

    // R9
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(trig_rise && trig_fall));

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_rise |=> !trig_rise);

    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_fall |=> !trig_fall);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!trig_level && !trig_rise && !trig_fall));

endmodule

// File: tb/ext_trig_conditioner_test.sv
module ext_trig_conditioner_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_pin = 1'b0;
    logic [1:0] cmp_out = '0;
    logic [2:0] wdg_flag = '0;
    logic [3:0] cfg_src = '0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_div = '0;
    logic [3:0] cfg_filt = '0;
    logic       samp_en = 1'b1;
    logic       trig_level, trig_rise, trig_fall;

    int checks = 0;
    int failures = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_trig_conditioner uut (
        .clk(clk), .rst(rst), .trig_pin(trig_pin), .cmp_out(cmp_out),
        .wdg_flag(wdg_flag), .cfg_src(cfg_src), .cfg_invert(cfg_invert),
        .cfg_div(cfg_div), .cfg_filt(cfg_filt), .samp_en(samp_en),
        .trig_level(trig_level), .trig_rise(trig_rise), .trig_fall(trig_fall)
    );

    always @(negedge clk) begin
        if (trig_rise) rise_cnt++;
        if (trig_fall) fall_cnt++;
    end

    function automatic logic exp_src(input logic [3:0] code, input logic p,
                                     input logic [1:0] c, input logic [2:0] w,
                                     input logic inv);
        logic v;
        case (code)
            4'd0: v = p;
            4'd1: v = c[0];
            4'd2: v = c[1];
            4'd3: v = w[0];
            4'd4: v = w[1];
            4'd5: v = w[2];
            default: v = 1'b0;
        endcase
        return v ^ inv;
    endfunction

    function automatic int ratio(input logic [1:0] code);
        return 1 << code;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic pin_pulses(input int count);
        for (int i = 0; i < count; i++) begin
            trig_pin = 1'b1;
            tick(1 + ($urandom % 4));
            trig_pin = 1'b0;
            tick(1 + ($urandom % 4));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int r0, f0;
        void'($urandom(32'd1357));
        tick(3);
        // R1: reset state
        chk("R1 level in reset", trig_level, 0);
        chk("R1 rise in reset", trig_rise, 0);
        rst = 1'b0;
        tick(1);
        chk("R1 level after reset", trig_level, 0);
        chk("R1 fall after reset", trig_fall, 0);

        // R2 / R3: every source code, both polarities, random candidate vectors
        for (int inv = 0; inv < 2; inv++) begin
            cfg_invert = inv[0];
            for (int code = 0; code < 16; code++) begin
                cfg_src = code[3:0];
                for (int v = 0; v < 4; v++) begin
                    logic [5:0] vec;
                    vec = 6'($urandom);
                    if (v == 3) vec = 6'h3F;
                    trig_pin = vec[0];
                    cmp_out  = vec[2:1];
                    wdg_flag = vec[5:3];
                    tick(8);
                    chk(inv ? "R3 inverted source" : "R2 source select", trig_level,
                        exp_src(cfg_src, trig_pin, cmp_out, wdg_flag, cfg_invert));
                end
            end
        end
        cfg_invert = 1'b0;
        cfg_src = 4'd0;
        trig_pin = 1'b0;
        cmp_out = '0;
        wdg_flag = '0;
        tick(8);

        // R4 / R9: exact latency and strobes
        trig_pin = 1'b1;
        tick(3);
        chk("R4 not yet risen", trig_level, 0);
        tick(1);
        chk("R4 level risen at 4th edge", trig_level, 1);
        chk("R9 rise strobe", trig_rise, 1);
        chk("R9 no fall with rise", trig_fall, 0);
        tick(1);
        chk("R9 rise strobe one clock", trig_rise, 0);
        trig_pin = 1'b0;
        tick(3);
        chk("R4 not yet fallen", trig_level, 1);
        tick(1);
        chk("R4 level fallen at 4th edge", trig_level, 0);
        chk("R9 fall strobe", trig_fall, 1);
        tick(1);
        chk("R9 fall strobe one clock", trig_fall, 0);

        // R5: all four ratios with random pulse widths
        for (int d = 0; d < 4; d++) begin
            cfg_div = d[1:0];
            tick(6);
            r0 = rise_cnt;
            pin_pulses(16);
            tick(10);
            chk("R5 output rises for ratio", rise_cnt - r0, 16 / ratio(cfg_div));
        end

        // R6: rewriting the divide code clears the divider
        cfg_div = 2'd3;
        tick(6);
        pin_pulses(4);
        tick(8);
        chk("R6 /8 toggled after 4 edges", trig_level, 1);
        pin_pulses(2);
        cfg_div = 2'd2;
        tick(8);
        chk("R6 output cleared by write", trig_level, 0);
        pin_pulses(1);
        tick(8);
        chk("R6 count restarts from zero", trig_level, 0);
        pin_pulses(1);
        tick(8);
        chk("R6 toggles after two edges", trig_level, 1);
        cfg_div = 2'd0;
        tick(8);

        // R7: glitch rejection at the boundary
        for (int k = 0; k < 6; k++) begin
            int n;
            n = (k == 0) ? 1 : (k == 1) ? 15 : 1 + int'($urandom % 15);
            cfg_filt = 4'(n);
            tick(6);
            r0 = rise_cnt;
            trig_pin = 1'b1;
            tick(n);
            trig_pin = 1'b0;
            tick(n + 12);
            chk("R7 short pulse ignored", rise_cnt - r0, 0);
            chk("R7 level low after short pulse", trig_level, 0);
            f0 = fall_cnt;
            trig_pin = 1'b1;
            tick(n + 1);
            trig_pin = 1'b0;
            tick(2 * n + 14);
            chk("R7 long pulse taken", rise_cnt - r0, 1);
            chk("R7 long pulse ends", fall_cnt - f0, 1);
        end

        // R8: sampling enable gates the filter
        cfg_filt = 4'd3;
        tick(6);
        samp_en = 1'b0;
        trig_pin = 1'b1;
        tick(20);
        chk("R8 frozen while sampling off", trig_level, 0);
        samp_en = 1'b1;
        tick(8);
        chk("R8 resumes when sampling on", trig_level, 1);

        done = 1;
        finish_run();
    end

endmodule